// File: doc/BRIEF.md
# Serial Control Port with Rotating Channel Enables

This block is the microcontroller-facing control port of a four-channel line-card device. A host opens a window by pulling a select line low and then runs one full-duplex 8-bit exchange on a control clock. During the exchange the block returns an 8-bit status byte and receives an 8-bit control byte. The block applies the control byte only when the host completes all eight bits.

For each accepted window the block pulls one active-low channel enable low. The channels take turns in a fixed order. While its enable is low, a channel's supervision bits are copied into a status latch, and the channel's line interface can take the control byte. The status latch is copied into the outgoing shift register when a window opens, so the status read in a window comes from the channel that was strobed before it. While select stays high, every falling control-clock edge strobes the next channel, which keeps the status latch current.

All pins are sampled on a faster system clock, and their edges are found there. Select must stay high for a programmable number of control-clock falls between windows. A window that opens too early is ignored and sets a sticky error flag.

Top module: `scp_ctrl_port`

## Requirements
- R1: After reset all enables are high, the control byte is zero, the error flag is low, the status latch is zero, and the first channel to be strobed is channel 0.
- R2: When an accepted window opens, the status latch is loaded into the outgoing shift register. Bit 7 is on do_o before the first falling cclk_i edge. Each later bit, MSB first, appears after a rising cclk_i edge, so do_o is stable through every falling edge.
- R3: di_i is sampled MSB first on the falling cclk_i edges of an accepted window. If select is still low at the eighth falling edge, ctrl_o takes the received byte.
- R4: If select rises before the eighth falling edge, ctrl_o keeps its previous value.
- R5: An accepted window drives exactly one enable low for as long as select stays low. The channel index is the pointer, and the pointer then advances by one, wrapping from 3 to 0.
- R6: While select is idle high, each falling cclk_i edge drives the pointer channel's enable low for one system-clock cycle and advances the pointer.
- R7: While enable c is low, the status latch loads sts_i[8c+7:8c]. The latch is not copied into the outgoing register again inside a window, so the status read reflects the channel strobed before the window.
- R8: A select fall is accepted only after at least MIN_HIGH falling cclk_i edges with select high since the last accepted window (reset counts as satisfied). An early fall causes no enable, no shift and no control update, and it sets err_o. err_o stays set until reset.
- R9: At most one enable is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all port pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cclk_i | input | 1 | Control clock from the host, synchronous to clk_i |
| csel_i | input | 1 | Window select, active low |
| di_i | input | 1 | Serial control data from the host |
| sts_i | input | N_CH*W | Supervision bits; channel c at [c*W +: W] |
| do_o | output | 1 | Serial status data to the host |
| en_no | output | N_CH | Per-channel enables, active low |
| ctrl_o | output | W | Last complete control byte |
| err_o | output | 1 | Sticky flag for a window opened too early |

## Verification
The bench changes the per-channel status inputs between windows and checks that each window returns the status of the channel strobed before it. A design that reloaded the latch during the window, or read the live channel, would return the wrong byte. It aborts a window after five bits, and a design that applied partial bytes would change ctrl_o. It opens windows with too few idle clocks and with none. A design without the gap rule would strobe an enable, advance the rotation and overwrite the control byte. The bench also interleaves idle strobes with windows, so a pointer that only moved per window would select the wrong channel after the wrap.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    SCP_IDLE = 2'd0,
    SCP_XFER = 2'd1,
    SCP_HOLD = 2'd2,
    SCP_REJ  = 2'd3
  } scp_state_e;
endpackage

// File: rtl/scp_edge.sv
module scp_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '1;
    else         q <= sig_i;

  assign fall_o = q & ~sig_i;
  assign rise_o = ~q & sig_i;
endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic         di_i,
  output logic         do_o,
  output logic         done_o,
  output logic [W-1:0] byte_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  tx;
  logic [W-2:0]  rx;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx  <= '0;
      rx  <= '0;
      cnt <= '0;
    end else if (load_i) begin
      tx  <= load_val_i;
      cnt <= '0;
    end else begin
      if (run_i && fall_i) begin
        rx  <= {rx[W-3:0], di_i};
        cnt <= cnt + 1'b1;
      end
      // advance only after the host has taken the current bit
      if (run_i && rise_i && cnt != '0) tx <= {tx[W-2:0], 1'b0};
    end
  end

  assign do_o   = tx[W-1];
  assign done_o = run_i && fall_i && (cnt == CW'(W - 1));
  assign byte_o = {rx, di_i};
endmodule

// File: rtl/scp_enseq.sv
module scp_enseq #(
  parameter int N_CH = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  start_i,
  input  logic                                  tick_i,
  input  logic                                  hold_i,
  output logic [N_CH-1:0]                       en_no,
  output logic [(N_CH > 1 ? $clog2(N_CH) : 1)-1:0] ch_o,
  output logic                                  act_o
);
  localparam int CHW = N_CH > 1 ? $clog2(N_CH) : 1;

  logic [CHW-1:0] ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr   <= '0;
      ch_o  <= '0;
      act_o <= 1'b0;
    end else if (start_i || tick_i) begin
      ch_o  <= ptr;
      act_o <= 1'b1;
      ptr   <= (ptr == CHW'(N_CH - 1)) ? '0 : ptr + 1'b1;
    end else if (!hold_i) begin
      act_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_en
    assign en_no[g] = ~(act_o && ch_o == CHW'(g));
  end
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
  import scp_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int W        = 8,
  parameter int MIN_HIGH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cclk_i,
  input  logic            csel_i,
  input  logic            di_i,
  input  logic [N_CH*W-1:0] sts_i,
  output logic            do_o,
  output logic [N_CH-1:0] en_no,
  output logic [W-1:0]    ctrl_o,
  output logic            err_o
);
  localparam int CHW = N_CH > 1 ? $clog2(N_CH) : 1;
  localparam int GW  = $clog2(MIN_HIGH + 1);

  logic [1:0] fall, rise;
  logic       cclk_fall, cclk_rise, csel_fall, csel_rise;

  scp_edge #(.W(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({csel_i, cclk_i}),
    .fall_o(fall),
    .rise_o(rise)
  );
  assign {csel_fall, cclk_fall} = fall;
  assign {csel_rise, cclk_rise} = rise;

  scp_state_e st_q, st_d;
  logic [GW-1:0] gap_q;
  logic gap_ok, accept, reject, run, hold, tick, done;
  logic [W-1:0] stat_q, rx_byte, ctrl_q;
  logic [CHW-1:0] en_ch;
  logic en_act;

  assign gap_ok = gap_q >= GW'(MIN_HIGH);

  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    reject = 1'b0;
    unique case (st_q)
      SCP_IDLE: if (csel_fall) begin
        if (gap_ok) begin accept = 1'b1; st_d = SCP_XFER; end
        else        begin reject = 1'b1; st_d = SCP_REJ;  end
      end
      SCP_XFER: if (csel_rise) st_d = SCP_IDLE;
                else if (done) st_d = SCP_HOLD;
      default:  if (csel_rise) st_d = SCP_IDLE;
    endcase
  end

  assign run  = (st_q == SCP_XFER) && !csel_i;
  assign hold = (st_q == SCP_XFER || st_q == SCP_HOLD) && !csel_rise;
  assign tick = (st_q == SCP_IDLE) && csel_i && cclk_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SCP_IDLE;
      gap_q  <= GW'(MIN_HIGH);
      stat_q <= '0;
      ctrl_q <= '0;
      err_o  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept)               gap_q <= '0;
      else if (tick && !gap_ok) gap_q <= gap_q + 1'b1;
      if (en_act) stat_q <= sts_i[en_ch*W +: W];
      if (done)   ctrl_q <= rx_byte;
      if (reject) err_o  <= 1'b1;
    end
  end

  scp_shift #(.W(W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(stat_q),
    .run_i     (run),
    .fall_i    (cclk_fall),
    .rise_i    (cclk_rise),
    .di_i      (di_i),
    .do_o      (do_o),
    .done_o    (done),
    .byte_o    (rx_byte)
  );

  scp_enseq #(.N_CH(N_CH)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .tick_i (tick),
    .hold_i (hold),
    .en_no  (en_no),
    .ch_o   (en_ch),
    .act_o  (en_act)
  );

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/scp_ctrl_port_chk.sv
module scp_ctrl_port_chk #(
  parameter int N_CH = 4,
  parameter int W    = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cclk_i,
  input logic            csel_i,
  input logic            do_o,
  input logic [N_CH-1:0] en_no,
  input logic [W-1:0]    ctrl_o,
  input logic            err_o
);
  assert_one_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~en_no));

  assert_ctrl_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(!csel_i));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_enable_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_no != '1) && ($past(en_no) != '1) && !csel_i && $past(!csel_i) && $past(!csel_i, 2)
      |-> $stable(en_no));

  assert_do_stable_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csel_i && $past(!csel_i) && !cclk_i && $past(!cclk_i) |-> $stable(do_o));
endmodule

bind scp_ctrl_port scp_ctrl_port_chk #(.N_CH(N_CH), .W(W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cclk_i(cclk_i),
  .csel_i(csel_i),
  .do_o  (do_o),
  .en_no (en_no),
  .ctrl_o(ctrl_o),
  .err_o (err_o)
);

// File: tb/scp_ctrl_port_test.sv
module scp_ctrl_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int MIN_HIGH   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cclk = 1'b1, csel = 1'b1, di = 1'b0;
  logic [31:0] sts = 32'h3B_C6_5C_A3;
  logic do_w, err_w;
  logic [3:0] en_w;
  logic [7:0] ctrl_w;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scp_ctrl_port #(.N_CH(4), .W(8), .MIN_HIGH(MIN_HIGH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cclk_i(cclk), .csel_i(csel), .di_i(di),
    .sts_i(sts), .do_o(do_w), .en_no(en_w), .ctrl_o(ctrl_w), .err_o(err_w)
  );

  typedef struct { string req; string what; int val; } item_t;
  item_t exp_q[$];
  int    act_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  int ptr = 0, gap = MIN_HIGH;
  logic [7:0] last_val = 8'h00, ctrl_exp = 8'h00;
  bit err_exp = 0;

  task automatic push(input string req, input string what, input int exp, input int act);
    exp_q.push_back('{req, what, exp});
    act_q.push_back(act);
  endtask

  always @(posedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      int a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      checks++;
      if (a != e.val) begin
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", e.req, e.what, a, e.val);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int en_idx(input logic [3:0] e);
    int n = 0, idx = -1;
    for (int i = 0; i < 4; i++) if (!e[i]) begin n++; idx = i; end
    return (n > 1) ? 9 : idx;
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      cclk = 1'b0;
      cyc(1);
      push("R6", "idle strobe channel", ptr, en_idx(en_w));
      last_val = sts[ptr*8 +: 8];
      ptr = (ptr + 1) % 4;
      if (gap < MIN_HIGH) gap++;
      cyc(1);
      push("R6", "idle strobe ends", -1, en_idx(en_w));
      cyc(HALF - 2);
      cclk = 1'b1;
      cyc(HALF);
    end
  endtask

  task automatic window(input logic [7:0] di_b, input int nbits);
    bit acc;
    logic [7:0] got;
    int en_seen;
    acc = (gap >= MIN_HIGH);
    csel = 1'b0;
    cyc(2);
    got = '0;
    en_seen = en_idx(en_w);
    for (int i = 0; i < nbits; i++) begin
      di = di_b[7-i];
      cyc(HALF);
      got = {got[6:0], do_w};
      cclk = 1'b0;
      cyc(HALF);
      cclk = 1'b1;
      cyc(HALF);
    end
    csel = 1'b1;
    cyc(2);
    if (acc) begin
      push("R5", "window channel", ptr, en_seen);
      push("R7", "status lag byte", int'(last_val >> (8 - nbits)), int'(got));
      last_val = sts[ptr*8 +: 8];
      ptr = (ptr + 1) % 4;
      gap = 0;
      if (nbits == 8) begin
        ctrl_exp = di_b;
        push("R3", "ctrl applied", ctrl_exp, ctrl_w);
      end else begin
        push("R4", "ctrl kept on abort", ctrl_exp, ctrl_w);
      end
    end else begin
      err_exp = 1;
      push("R8", "no enable on early window", -1, en_seen);
      push("R8", "ctrl kept on early window", ctrl_exp, ctrl_w);
    end
    push("R8", "error flag", err_exp, err_w);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    push("R1", "enables high", 4'hF, en_w);
    push("R1", "ctrl zero", 0, ctrl_w);
    push("R1", "err low", 0, err_w);
    push("R1", "do low", 0, do_w);
    // R1/R2: first window returns zero latch and strobes channel 0
    window(8'hA5, 8);
    idle(2);
    // R2/R7: status of channel 2 returned, channel 3 strobed
    window(8'h3C, 8);
    sts = 32'h96_E1_0F_72;
    idle(3);
    // R4: abort after five bits
    window(8'hFF, 5);
    // R8: no idle gap at all
    window(8'h11, 8);
    idle(2);
    window(8'h96, 8);
    sts = 32'h4D_B2_27_D8;
    // R8: gap of one is too short
    idle(1);
    window(8'h22, 8);
    idle(1);
    // R5: pointer wrapped through channel 3 to 0
    window(8'h01, 8);
    cyc(4);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule